// File: doc/BRIEF.md
# Serial Timekeeper Register Transfer Engine

This block sits between a host's memory cycles and the eight byte-wide registers of a timekeeper. Once an external unlock detector raises an access-enable, the engine treats each memory cycle as a one-bit transfer on data bit 0. The strobe that is asserted sets the direction of each cycle. A write strobe shifts one host bit into a holding image. A read strobe returns one bit of the time that was captured when access began. After 64 single-bit transfers the engine reports completion, and the unlock logic then leaves access mode.

The stream runs least significant bit first. It starts at bit 0 of register 0 and ends at bit 7 of register 7. The register order is: hundredths of a second, seconds, minutes, hours (12/24 select in bit 7, AM/PM in bit 5), day of week (oscillator enable in bit 5, reset disable in bit 4), date, month, year. The engine does not decode these fields. It only keeps their byte and bit positions in the stream. New time is handed to the timekeeper as one 64-bit word with a single strobe, and only when the last bit of the stream arrives as a write. A power fail, a drop of access-enable or a reset in mid-stream abandons the transfer and commits nothing.

Top module: `rtc_bitxfer`

## Requirements
- R1: In the first clock cycle in which `acc_en` is high and `pfail` is low, with the engine idle, `time_in` is captured. Every read in the following transfer returns this captured value, whatever `time_in` does afterwards.
- R2: Transfer `i` of a stream (i = 0..63) carries bit `i` of the 64-bit word. Register k occupies bits [8k+7:8k], and k runs in the order hundredths, seconds, minutes, hours, day, date, month, year.
- R3: A read cycle is `rd_stb` high with `wr_stb` low while a transfer is active. In the clock cycle after a read cycle, `dout_en` is 1 and `dout` holds the addressed bit. At every other time `dout_en` is 0 and `dout` is 0.
- R4: A write cycle is `wr_stb` high with `rd_stb` low while a transfer is active. It stores `din` at the current stream position and advances the position by one.
- R5: `wb_stb` pulses for exactly one cycle, with `wb_data` holding the image, only when transfer 63 is a write cycle. Positions that were read rather than written keep the captured snapshot value.
- R6: `xfer_done` pulses for one cycle after the 64th transfer, and never earlier. After that pulse, no new transfer starts until `acc_en` has been seen low.
- R7: If `pfail` is high or `acc_en` is low during an active transfer, the transfer ends without `wb_stb` or `xfer_done`. Strobes are then ignored until `acc_en` goes low and high again, and the next transfer restarts at bit 0.
- R8: A cycle with both strobes high, and any strobe outside an active transfer, moves no bit and does not advance the position.
- R9: Synchronous active-high `rst` returns the engine to idle. In the cycle after reset, `dout_en`, `dout`, `wb_stb` and `xfer_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access mode granted by the unlock detector |
| pfail | input | 1 | Supply out of tolerance; aborts a transfer |
| wr_stb | input | 1 | One-cycle pulse marking a host write cycle |
| rd_stb | input | 1 | One-cycle pulse marking a host read cycle |
| din | input | 1 | Host data bit 0 on a write cycle |
| time_in | input | 64 | Live timekeeper registers, register k at bits [8k+7:8k] |
| dout | output | 1 | Read data bit, valid while dout_en is high |
| dout_en | output | 1 | Drive enable for the data bit |
| wb_data | output | 64 | Image handed to the timekeeper, valid with wb_stb |
| wb_stb | output | 1 | One-cycle commit strobe |
| xfer_done | output | 1 | One-cycle pulse after the 64th transfer |

## Verification
The hardest state to reach is a stream that mixes directions and still commits. Reads must return the captured snapshot while earlier positions are being overwritten, and the final write must merge both kinds of bit. The bench alternates read and write cycles across several snapshot and data patterns and rebuilds the expected commit word arithmetically. It also starts streams that it then cuts short by a power-fail pulse, a drop of access-enable or a reset. After each cut it re-enters and reads a fresh snapshot from bit 0, which shows that nothing was committed and that the position was rewound.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HOLD = 2'd2
  } rbx_state_e;
endpackage

// File: rtl/rbx_seq.sv
module rbx_seq
  import rbx_pkg::*;
#(
  parameter int NBITS = 64,
  parameter int PW    = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          pfail,
  input  logic          wr_stb,
  input  logic          rd_stb,
  output logic          load,
  output logic          step_wr,
  output logic          step_rd,
  output logic          last,
  output logic          in_xfer,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST_IDX = PW'(NBITS - 1);

  rbx_state_e state;
  logic       ok, single, step;

  always_comb begin
    in_xfer = (state == ST_XFER);
    ok      = in_xfer && acc_en && !pfail;
    single  = wr_stb ^ rd_stb;
    step    = ok && single;
    step_wr = step && wr_stb;
    step_rd = step && rd_stb;
    last    = step && (ptr == LAST_IDX);
    load    = (state == ST_IDLE) && acc_en && !pfail && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ptr   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          state <= ST_XFER;
          ptr   <= '0;
        end
        ST_XFER: begin
          if (!acc_en || pfail) state <= ST_HOLD;
          else if (last)        state <= ST_HOLD;
          else if (step)        ptr   <= ptr + PW'(1);
        end
        ST_HOLD: if (!acc_en) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbx_store.sv
module rbx_store #(
  parameter int NBITS = 64,
  parameter int PW    = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             load,
  input  logic [NBITS-1:0] snap,
  input  logic             wr_en,
  input  logic [PW-1:0]    idx,
  input  logic             din,
  output logic             rd_bit,
  output logic [NBITS-1:0] image
);
  always_ff @(posedge clk) begin
    if (load)       image      <= snap;
    else if (wr_en) image[idx] <= din;
  end

  assign rd_bit = image[idx];
endmodule

// File: rtl/rtc_bitxfer.sv
module rtc_bitxfer #(
  parameter int NREG  = 8,
  parameter int RBITS = 8,
  parameter int NBITS = NREG * RBITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             pfail,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             din,
  input  logic [NBITS-1:0] time_in,
  output logic             dout,
  output logic             dout_en,
  output logic [NBITS-1:0] wb_data,
  output logic             wb_stb,
  output logic             xfer_done
);
  localparam int PW = $clog2(NBITS);

  logic          load, step_wr, step_rd, last, in_xfer, rd_bit;
  logic [PW-1:0] ptr;

  rbx_seq #(.NBITS(NBITS), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .acc_en(acc_en), .pfail(pfail),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .load(load),
    .step_wr(step_wr), .step_rd(step_rd), .last(last),
    .in_xfer(in_xfer), .ptr(ptr)
  );

  rbx_store #(.NBITS(NBITS), .PW(PW)) u_store (
    .clk(clk), .load(load), .snap(time_in), .wr_en(step_wr),
    .idx(ptr), .din(din), .rd_bit(rd_bit), .image(wb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= 1'b0;
      dout_en   <= 1'b0;
      wb_stb    <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      dout      <= step_rd && rd_bit;
      dout_en   <= step_rd;
      wb_stb    <= last && step_wr;
      xfer_done <= last;
    end
  end
endmodule

// File: rtl/rtc_bitxfer_chk.sv
module rtc_bitxfer_chk (
  input logic clk,
  input logic rst,
  input logic acc_en,
  input logic pfail,
  input logic wr_stb,
  input logic rd_stb,
  input logic in_xfer,
  input logic dout,
  input logic dout_en,
  input logic wb_stb,
  input logic xfer_done
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R3
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(rd_stb && !wr_stb && in_xfer));

  // R3
  quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> !dout);

  // R5
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    wb_stb |-> (xfer_done && $past(wr_stb && !rd_stb)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R7
  pfail_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (pfail || !acc_en) |=> (!dout_en && !wb_stb && !xfer_done));

  // R8
  both_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && rd_stb) |=> (!dout_en && !xfer_done));

  // R9
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1 && !rst)
      reset_clear_chk: assert (!dout_en && !dout && !wb_stb && !xfer_done);
  end
endmodule

bind rtc_bitxfer rtc_bitxfer_chk u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .pfail(pfail),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .in_xfer(in_xfer),
  .dout(dout), .dout_en(dout_en), .wb_stb(wb_stb), .xfer_done(xfer_done)
);

// File: tb/rtc_bitxfer_tb.sv
module rtc_bitxfer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, pfail = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, din = 1'b0;
  logic [63:0] time_in = '0;
  logic        dout, dout_en, wb_stb, xfer_done;
  logic [63:0] wb_data;

  int total = 0;
  int bad   = 0;
  logic o_dout, o_en, o_wb, o_done;
  logic [63:0] o_data;

  always #2 clk = ~clk;

  rtc_bitxfer u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .pfail(pfail),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .time_in(time_in),
    .dout(dout), .dout_en(dout_en), .wb_data(wb_data),
    .wb_stb(wb_stb), .xfer_done(xfer_done)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // inputs set at a falling edge, outputs sampled at the next falling edge
  task automatic cyc(input logic w, input logic r, input logic d);
    wr_stb = w; rd_stb = r; din = d;
    @(negedge clk);
    o_dout = dout; o_en = dout_en; o_wb = wb_stb; o_done = xfer_done; o_data = wb_data;
    wr_stb = 1'b0; rd_stb = 1'b0; din = 1'b0;
  endtask

  task automatic open_access();
    acc_en = 1'b0; cyc(0, 0, 0);
    acc_en = 1'b1; cyc(0, 0, 0);
  endtask

  function automatic logic [63:0] pat(input int k);
    return (64'h9E3779B97F4A7C15 * 64'(k + 1)) ^ (64'h0F0F_33CC_5A5A_00FF << (k % 7));
  endfunction

  // full read of a snapshot; time_in is scrambled after entry (R1)
  task automatic read_all(input logic [63:0] snap);
    int early = 0;
    time_in = snap;
    open_access();
    time_in = ~snap;
    for (int i = 0; i < 64; i++) begin
      cyc(0, 1, 0);
      check(o_en === 1'b1, "R3 dout_en on read", 64'(o_en), 64'd1);
      check(o_dout === snap[(i/8)*8 + i%8], "R2 R1 stream bit", 64'(o_dout), 64'(snap[i]));
      if (i < 63 && o_done) early++;
      if (i == 63) begin
        check(o_done === 1'b1, "R6 done after 64th", 64'(o_done), 64'd1);
        check(o_wb === 1'b0, "R5 no commit when last is read", 64'(o_wb), 64'd0);
      end
      if (i % 16 == 5) begin
        cyc(0, 0, 0);
        check(o_en === 1'b0 && o_dout === 1'b0, "R3 idle data low", 64'({o_en, o_dout}), 64'd0);
      end
    end
    check(early == 0, "R6 done not early", 64'(early), 64'd0);
  endtask

  task automatic write_all(input logic [63:0] snap, input logic [63:0] w);
    time_in = snap;
    open_access();
    for (int i = 0; i < 64; i++) begin
      cyc(1, 0, w[i]);
      if (i < 63) check(o_wb === 1'b0, "R5 no early commit", 64'(o_wb), 64'd0);
    end
    check(o_wb === 1'b1 && o_done === 1'b1, "R5 R4 commit strobe", 64'({o_wb, o_done}), 64'd3);
    check(o_data === w, "R4 committed word", o_data, w);
    cyc(0, 0, 0);
    check(o_wb === 1'b0, "R5 strobe one cycle", 64'(o_wb), 64'd0);
  endtask

  task automatic mixed(input logic [63:0] snap, input logic [63:0] w);
    logic [63:0] exp;
    exp = snap;
    time_in = snap;
    open_access();
    for (int i = 0; i < 64; i++) begin
      if (i % 2 == 0) begin
        cyc(0, 1, 0);
        check(o_en === 1'b1 && o_dout === snap[i], "R3 mixed read", 64'(o_dout), 64'(snap[i]));
      end else begin
        cyc(1, 0, w[i]);
        exp[i] = w[i];
      end
    end
    check(o_wb === 1'b1, "R5 mixed commit", 64'(o_wb), 64'd1);
    check(o_data === exp, "R5 merged image", o_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    cyc(0, 0, 0);
    check(o_en === 0 && o_dout === 0 && o_wb === 0 && o_done === 0, "R9 reset state",
          64'({o_en, o_dout, o_wb, o_done}), 64'd0);

    // R8: strobes with access low are ignored
    acc_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cyc(0, 1, 0);
      check(o_en === 1'b0, "R8 read while idle", 64'(o_en), 64'd0);
      cyc(1, 0, 1);
      check(o_wb === 1'b0 && o_done === 1'b0, "R8 write while idle", 64'({o_wb, o_done}), 64'd0);
    end

    for (int k = 0; k < 4; k++) begin
      read_all(pat(k));
      write_all(pat(k + 10), pat(k + 20));
      mixed(pat(k + 30), pat(k + 40));
    end

    // R2: byte order hundredths..year, register k at [8k+7:8k]
    read_all({8'h99, 8'h12, 8'h31, 8'h27, 8'hA3, 8'h59, 8'h58, 8'h42});

    // R6: after done with acc_en still high, no re-entry
    cyc(0, 1, 0);
    check(o_en === 1'b0, "R6 no re-entry while acc_en high", 64'(o_en), 64'd0);

    // R8: both strobes together do not advance
    time_in = pat(50);
    open_access();
    cyc(1, 1, 1);
    check(o_en === 1'b0 && o_wb === 1'b0, "R8 both strobes ignored", 64'({o_en, o_wb}), 64'd0);
    cyc(0, 1, 0);
    check(o_dout === pat(50)[0], "R8 position unchanged", 64'(o_dout), 64'(pat(50)[0]));

    // R7: access dropped mid-write, nothing committed, restart at bit 0
    time_in = pat(51);
    open_access();
    for (int i = 0; i < 30; i++) cyc(1, 0, 1'b1);
    acc_en = 1'b0;
    cyc(1, 0, 1);
    check(o_wb === 1'b0 && o_done === 1'b0, "R7 drop aborts", 64'({o_wb, o_done}), 64'd0);
    read_all(pat(52));

    // R7: power fail mid-write, strobes ignored until access cycles
    time_in = pat(53);
    open_access();
    for (int i = 0; i < 40; i++) cyc(1, 0, 1'b0);
    pfail = 1'b1;
    cyc(1, 0, 1);
    pfail = 1'b0;
    check(o_wb === 1'b0 && o_done === 1'b0, "R7 pfail aborts", 64'({o_wb, o_done}), 64'd0);
    for (int i = 0; i < 30; i++) begin
      cyc(0, 1, 0);
      check(o_en === 1'b0 && o_done === 1'b0, "R7 strobes ignored after abort", 64'({o_en, o_done}), 64'd0);
    end
    read_all(pat(54));

    // R9: reset mid-transfer, restart at bit 0
    time_in = pat(55);
    open_access();
    for (int i = 0; i < 20; i++) cyc(0, 1, 0);
    rst = 1'b1;
    cyc(0, 1, 0);
    rst = 1'b0;
    check(o_en === 1'b0, "R9 reset mid transfer", 64'(o_en), 64'd0);
    read_all(pat(56));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule